// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm counted in seconds. Software loads a number of seconds into a load register. While the run bit is set, every one-second tick pulse lowers the remaining count by one. On the tick that takes the count from 1 to 0, the block sets a sticky pending flag and the count stays at 0.

The pending flag is cleared by writing a 1 to it. It drives two outputs, each through its own enable bit. One output is an interrupt request. The other is a system wakeup request.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge. Read data is registered and appears one clock after the address. The one-second tick comes from outside the block.

To reprogram the alarm, software clears the run bit, clears the pending flag, loads 0, waits, loads the new interval and then sets the run bit again.

Top module: `sec_alarm`

## Requirements
- R1: After synchronous reset the remaining count, the stored load value, all three enable bits and the pending flag are 0, and irq, wake and rdata are 0.
- R2: A write to word offset 0 sets the remaining count to the written value on that clock edge. This holds whether or not the run bit is set, and it overrides a tick in the same cycle. Loading 0 never sets the pending flag.
- R3: Reading offset 1 returns the remaining count, and reading offset 0 returns the last loaded value. rdata shows the register selected by addr in the previous cycle. Writes to offset 1 have no effect.
- R4: Bit 0 of offset 2 is the run bit. A tick while run is 1 and the count is non-zero lowers the count by exactly 1. A cycle without a tick leaves the count unchanged.
- R5: While the run bit is 0, ticks leave the count frozen.
- R6: A tick that moves the count from 1 to 0 sets the pending flag. At 0, further ticks change neither the count nor the flag.
- R7: Bit 0 of offset 4 reads the pending flag. Writing 1 to that bit clears the flag, and writing 0 to it has no effect.
- R8: If an expiry and a clearing write to offset 4 fall in the same cycle, the pending flag ends up set.
- R9: irq is a registered output. It equals (pending AND bit 0 of offset 3) as those stood one clock earlier.
- R10: wake is a registered output. It equals (pending AND bit 0 of offset 5) as those stood one clock earlier.
- R11: Offsets 2, 3 and 5 read back their bit 0 with all upper bits 0. Offsets 6 and 7 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's addr |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
Two events can land on the same clock edge: the tick that expires the count, and a software write of 1 to the pending bit. The bench sets this up directly. It loads 1, sets run, then drives a tick together with the clearing write, and afterwards expects the flag, irq and wake to be set. In a second case it drives a tick together with a load write and expects the loaded value to win. Random traffic with short load values brings about both overlaps many more times. A cycle-accurate bench model judges every cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFF_LOAD = 0;
  localparam int unsigned OFF_CUR  = 1;
  localparam int unsigned OFF_RUN  = 2;
  localparam int unsigned OFF_IEN  = 3;
  localparam int unsigned OFF_PEND = 4;
  localparam int unsigned OFF_WEN  = 5;
  localparam int unsigned N_EN     = 3;
  // index of each enable bit inside the en vector
  localparam int unsigned EN_RUN = 0;
  localparam int unsigned EN_IRQ = 1;
  localparam int unsigned EN_WAK = 2;
endpackage

// File: rtl/sa_counter.sv
module sa_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = tick && run && !load_wr && (count != '0);
  assign expire = step && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_wr) begin
      count <= load_val;
    end else if (step) begin
      count <= count - ONE;
    end
  end

  // R2
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    load_wr |=> count == $past(load_val));
  // R5
  frozen_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load_wr) |=> $stable(count));
  // R6
  zero_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load_wr) |=> count == '0);
  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !load_wr |=> count <= $past(count));
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [N_EN-1:0]   en,
  output logic              pend,
  output logic              load_wr,
  output logic [CNT_W-1:0]  load_q
);
  localparam int unsigned EN_OFF [N_EN] = '{OFF_RUN, OFF_IEN, OFF_WEN};

  logic clr;
  assign load_wr = wr_en && (addr == ADDR_W'(OFF_LOAD));
  assign clr     = wr_en && (addr == ADDR_W'(OFF_PEND)) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
    end else if (load_wr) begin
      load_q <= wdata[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_EN; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) begin
        en[g] <= 1'b0;
      end else if (wr_en && addr == ADDR_W'(EN_OFF[g])) begin
        en[g] <= wdata[0];
      end
    end
  end

  // expiry wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else begin
      pend <= expire | (pend & ~clr);
    end
  end

  // R8
  expire_sets_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend);
  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !expire) |=> !pend);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/sa_readmux.sv
module sa_readmux
  import sa_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  count,
  input  logic [N_EN-1:0]   en,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (int'(addr))
      OFF_LOAD: sel = DATA_W'(load_q);
      OFF_CUR:  sel = DATA_W'(count);
      OFF_RUN:  sel = DATA_W'(en[EN_RUN]);
      OFF_IEN:  sel = DATA_W'(en[EN_IRQ]);
      OFF_PEND: sel = DATA_W'(pend);
      OFF_WEN:  sel = DATA_W'(en[EN_WAK]);
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(addr) > OFF_WEN) |=> rdata == '0);
endmodule

// File: rtl/sec_alarm.sv
module sec_alarm
  import sa_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake
);
  logic [N_EN-1:0]  en;
  logic             pend, load_wr, expire;
  logic [CNT_W-1:0] load_q, count;

  sa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .en(en), .pend(pend), .load_wr(load_wr), .load_q(load_q)
  );

  sa_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(en[EN_RUN]), .load_wr(load_wr),
    .load_val(wdata[CNT_W-1:0]), .count(count), .expire(expire)
  );

  sa_readmux #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .addr(addr), .load_q(load_q), .count(count),
    .en(en), .pend(pend), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= pend & en[EN_IRQ];
      wake <= pend & en[EN_WAK];
    end
  end

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en[EN_IRQ] |=> !irq);
  // R10
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en[EN_WAK] |=> !wake);
  // R9
  irq_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && en[EN_IRQ]) |=> irq);
endmodule

// File: tb/sec_alarm_test.sv
module sec_alarm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_cnt, m_ld, m_rd;
  logic m_run, m_ie, m_we, m_pend, m_irq, m_wake;

  always #2.5 clk = ~clk;

  sec_alarm uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ld;
      3'd1: return m_cnt;
      3'd2: return {31'd0, m_run};
      3'd3: return {31'd0, m_ie};
      3'd4: return {31'd0, m_pend};
      3'd5: return {31'd0, m_we};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ld = 0; m_rd = 0; m_run = 0; m_ie = 0; m_we = 0;
    m_pend = 0; m_irq = 0; m_wake = 0;
  endtask

  // one clock: drive, clock, update model, compare outputs
  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d);
    logic ld, clr, ex;
    tick = t; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    ld  = w && a == 3'd0;
    clr = w && a == 3'd4 && d[0];
    ex  = t && m_run && !ld && m_cnt == 32'd1;
    m_rd   = model_read(a);
    m_irq  = m_pend & m_ie;
    m_wake = m_pend & m_we;
    if (ld) m_cnt = d;
    else if (t && m_run && m_cnt != 0) m_cnt = m_cnt - 1;
    if (ld) m_ld = d;
    if (w && a == 3'd2) m_run = d[0];
    if (w && a == 3'd3) m_ie = d[0];
    if (w && a == 3'd5) m_we = d[0];
    m_pend = ex | (m_pend & !clr);
    #1;
    check("R3/R11 rdata", rdata, m_rd);
    check("R9 irq", {31'd0, irq}, {31'd0, m_irq});
    check("R10 wake", {31'd0, wake}, {31'd0, m_wake});
    tick = 0; wr_en = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state, read each offset
    for (int i = 0; i < 8; i++) cyc(0, 0, 3'(i), 0);
    cyc(0, 0, 3'd1, 0);
    check("R1 count after reset", rdata, 32'd0);

    // R2 load while stopped, readback; R3 write to offset 1 ignored
    cyc(0, 1, 3'd0, 32'd3);
    cyc(0, 1, 3'd1, 32'hdead);
    cyc(1, 0, 3'd1, 0);
    cyc(0, 0, 3'd1, 0);
    check("R5 frozen while stopped", rdata, 32'd3);

    // R4/R6 run down to zero, ie and wake on
    cyc(0, 1, 3'd3, 32'd1);
    cyc(0, 1, 3'd5, 32'hffff_ffff);
    cyc(0, 1, 3'd2, 32'd1);
    for (int i = 0; i < 5; i++) cyc(1, 0, 3'd1, 0);
    cyc(0, 0, 3'd4, 0);
    check("R6 pending after expiry", rdata, 32'd1);
    check("R9 irq after expiry", {31'd0, irq}, 32'd1);
    check("R10 wake after expiry", {31'd0, wake}, 32'd1);

    // R7 write 0 keeps, write 1 clears
    cyc(0, 1, 3'd4, 32'd0);
    cyc(0, 0, 3'd4, 0);
    check("R7 write0 keeps pending", rdata, 32'd1);
    cyc(0, 1, 3'd4, 32'd1);
    cyc(0, 0, 3'd4, 0);
    check("R7 write1 clears pending", rdata, 32'd0);

    // R8 expiry and clear in same cycle
    cyc(0, 1, 3'd0, 32'd1);
    tick = 1; wr_en = 1; addr = 3'd4; wdata = 32'd1;
    cyc(1, 1, 3'd4, 32'd1);
    cyc(0, 0, 3'd4, 0);
    check("R8 expiry beats clear", rdata, 32'd1);

    // R2 load overrides tick; loading 0 never expires
    cyc(0, 1, 3'd4, 32'd1);
    cyc(1, 1, 3'd0, 32'd7);
    cyc(0, 0, 3'd1, 0);
    check("R2 load beats tick", rdata, 32'd7);
    cyc(1, 1, 3'd0, 32'd0);
    cyc(1, 0, 3'd4, 0);
    cyc(0, 0, 3'd4, 0);
    check("R2 load zero no pending", rdata, 32'd0);

    // R11 unused offsets ignore writes
    cyc(0, 1, 3'd6, 32'hffff_ffff);
    cyc(0, 1, 3'd7, 32'hffff_ffff);
    cyc(0, 0, 3'd6, 0);
    check("R11 offset 6 reads zero", rdata, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [2:0] a;
      logic [31:0] d;
      w = ($urandom % 10) < 3;
      a = 3'($urandom);
      d = (a == 3'd0) ? ($urandom % 6) : $urandom;
      cyc(($urandom % 10) < 4, w, a, d);
    end

    // R1 reset again mid-run
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    cyc(0, 0, 3'd1, 0);
    check("R1 count after second reset", rdata, 32'd0);

    done = 1;
    summary();
  end
endmodule